// File: doc/BRIEF.md
# SMBus Line Timing Watchdog

This block sits beside an SMBus slave port and watches the raw clock and data lines on the system clock. Once both lines have passed through a synchronizer, it finds message boundaries (START and STOP) and measures how long each line stays in each state. From these times it raises four outputs. A one-cycle abort pulse tells the port to drop the message in progress. A sticky flag reports that clock stretching inside the current message went over budget. A one-cycle calibration request fires when both lines have been held low for a long time. A one-cycle wake request fires when the bus moves while the pack is in its low-power ship state.

Stretching is counted separately for the two sides. Slave stretching is any clock-low cycle in which the local port is itself holding the clock low (`slv_hold_scl`). Master extension is any clock-low cycle, without the local hold, that comes after the nominal low time of that phase has already passed. Every time limit is a parameter given in system-clock cycles. The defaults are kept short so that simulation runs quickly. An integration scales them to the real millisecond and second windows.

Top module: `smb_line_watchdog`

## Requirements
- R1: During and after reset all four outputs are 0. Each output is registered. A change on `scl_in`/`sda_in` reaches the outputs three clock cycles later: two synchronizer stages plus the output register.
- R2: A START is the synchronized data line falling while the synchronized clock is high in both the current and the previous cycle. A STOP is the data line rising under the same clock condition. A START opens a message. A STOP closes it.
- R3: While a message is open, the synchronized clock staying low for `T_LOW_ABORT` consecutive cycles produces exactly one `abort_pulse`. With no message open, a long low clock produces no abort.
- R4: While a message is open, the clock staying high for `T_HIGH_ABORT` consecutive cycles produces one `abort_pulse`. The count restarts at every START and every clock fall.
- R5: Inside a message, once the clock-low cycles with `slv_hold_scl`=1 add up to `T_SLV_EXT`, `stretch_over` is set.
- R6: Inside a message, clock-low cycles with `slv_hold_scl`=0 that come after the first `T_LOW_NOMINAL` cycles of their low phase are added up. When that total reaches `T_MST_EXT`, `stretch_over` is set.
- R7: `stretch_over` stays set until the next START. Each START clears the flag and both cumulative totals.
- R8: Both synchronized lines staying low for `T_CAL` consecutive cycles produces exactly one `cal_req` pulse per episode. A new request is possible only after either line has gone high.
- R9: With `ship_mode`=1, every change of either synchronized line produces a `wake_req` pulse. With `ship_mode`=0, no wake is raised.
- R10: An abort closes the message. No further abort follows until a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| slv_hold_scl | input | 1 | Local port is holding the clock low (synchronous) |
| ship_mode | input | 1 | Low-power ship state is active |
| abort_pulse | output | 1 | One-cycle request to drop the current message |
| stretch_over | output | 1 | Cumulative stretch budget exceeded in this message |
| cal_req | output | 1 | One-cycle request for offset calibration |
| wake_req | output | 1 | One-cycle wake request from bus activity |

## Verification
The line patterns are:
- a clean message with short clock phases;
- a long low clock both inside and outside a message, which shows the abort depends on message state;
- a clock parked high after START;
- repeated low phases held either by the local port or by the far side, which shows the slave and master totals are kept apart;
- long and short both-low episodes, which show the once-per-episode calibration rule;
- line toggles with the ship state off and on.

A behavioural model in the bench follows every cycle. Hand-counted pulse totals per scenario back it up.

// File: rtl/lw_pkg.sv
package lw_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } lw_lines_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic moved;
    } lw_evt_t;

    function automatic int cnt_w(input int unsigned max_val);
        return $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/lw_sync.sv
module lw_sync
    import lw_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  lw_lines_t raw,
    output lw_lines_t cur,
    output lw_lines_t prev
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        lw_lines_t q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= g_stage[g-1].q;
            end
        end
    end

    assign cur = g_stage[STAGES-1].q;

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= cur;
    end
endmodule

// File: rtl/lw_sat_counter.sv
module lw_sat_counter
    import lw_pkg::*;
#(
    parameter int unsigned MAX = 16,
    localparam int W = cnt_w(MAX)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         reach
);
    // reach: this enabled cycle is the one that makes the count equal MAX
    assign reach = en && !clr && (cnt == W'(MAX - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)                 cnt <= '0;
        else if (en && cnt != W'(MAX))  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lw_cond_detect.sv
module lw_cond_detect
    import lw_pkg::*;
(
    input  lw_lines_t cur,
    input  lw_lines_t prev,
    output lw_evt_t   evt
);
    logic clk_high_both;

    always_comb begin
        clk_high_both = cur.scl && prev.scl;
        evt.start     = clk_high_both && prev.sda && !cur.sda;
        evt.stop      = clk_high_both && !prev.sda && cur.sda;
        evt.moved     = (cur.scl != prev.scl) || (cur.sda != prev.sda);
    end
endmodule

// File: rtl/smb_line_watchdog.sv
module smb_line_watchdog
    import lw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned T_LOW_ABORT   = 300,
    parameter int unsigned T_HIGH_ABORT  = 40,
    parameter int unsigned T_LOW_NOMINAL = 10,
    parameter int unsigned T_SLV_EXT     = 60,
    parameter int unsigned T_MST_EXT     = 40,
    parameter int unsigned T_CAL         = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic slv_hold_scl,
    input  logic ship_mode,
    output logic abort_pulse,
    output logic stretch_over,
    output logic cal_req,
    output logic wake_req
);
    localparam int LOW_W  = cnt_w(T_LOW_ABORT);
    localparam int HIGH_W = cnt_w(T_HIGH_ABORT);
    localparam int SLV_W  = cnt_w(T_SLV_EXT);
    localparam int MST_W  = cnt_w(T_MST_EXT);
    localparam int CAL_W  = cnt_w(T_CAL);

    lw_lines_t raw_lines, cur, prev;
    lw_evt_t   evt;
    logic      busy_q, start_seen;

    logic [LOW_W-1:0]  low_cnt;
    logic [HIGH_W-1:0] high_cnt;
    logic [SLV_W-1:0]  slv_cnt;
    logic [MST_W-1:0]  mst_cnt;
    logic [CAL_W-1:0]  cal_cnt;
    logic low_reach, high_reach, slv_reach, mst_reach, cal_reach;
    logic slv_en, mst_en, abort_d;

    assign raw_lines.scl = scl_in;
    assign raw_lines.sda = sda_in;
    assign start_seen    = evt.start;

    lw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw_lines), .cur(cur), .prev(prev)
    );

    lw_cond_detect u_cond (.cur(cur), .prev(prev), .evt(evt));

    lw_sat_counter #(.MAX(T_LOW_ABORT)) u_low (
        .clk(clk), .rst(rst), .clr(cur.scl), .en(!cur.scl),
        .cnt(low_cnt), .reach(low_reach)
    );

    lw_sat_counter #(.MAX(T_HIGH_ABORT)) u_high (
        .clk(clk), .rst(rst), .clr(!cur.scl || evt.start), .en(cur.scl),
        .cnt(high_cnt), .reach(high_reach)
    );

    assign slv_en = busy_q && !cur.scl && slv_hold_scl;
    assign mst_en = busy_q && !cur.scl && !slv_hold_scl
                    && (low_cnt >= LOW_W'(T_LOW_NOMINAL));

    lw_sat_counter #(.MAX(T_SLV_EXT)) u_slv (
        .clk(clk), .rst(rst), .clr(evt.start), .en(slv_en),
        .cnt(slv_cnt), .reach(slv_reach)
    );

    lw_sat_counter #(.MAX(T_MST_EXT)) u_mst (
        .clk(clk), .rst(rst), .clr(evt.start), .en(mst_en),
        .cnt(mst_cnt), .reach(mst_reach)
    );

    lw_sat_counter #(.MAX(T_CAL)) u_cal (
        .clk(clk), .rst(rst), .clr(cur.scl || cur.sda), .en(!cur.scl && !cur.sda),
        .cnt(cal_cnt), .reach(cal_reach)
    );

    assign abort_d = busy_q && (low_reach || high_reach);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q       <= 1'b0;
            abort_pulse  <= 1'b0;
            stretch_over <= 1'b0;
            cal_req      <= 1'b0;
            wake_req     <= 1'b0;
        end else begin
            if (evt.start)                 busy_q <= 1'b1;
            else if (evt.stop || abort_d)  busy_q <= 1'b0;
            abort_pulse  <= abort_d;
            stretch_over <= evt.start ? 1'b0 : (stretch_over || slv_reach || mst_reach);
            cal_req      <= cal_reach;
            wake_req     <= ship_mode && evt.moved;
        end
    end
endmodule

// File: rtl/smb_line_watchdog_chk.sv
module smb_line_watchdog_chk (
    input logic clk,
    input logic rst,
    input logic abort_pulse,
    input logic stretch_over,
    input logic cal_req,
    input logic wake_req,
    input logic ship_mode,
    input logic busy_q,
    input logic start_seen
);
    AST_ABORT_NEEDS_MSG: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> $past(busy_q));                       // R3
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);                        // R10
    AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> !busy_q);                             // R10
    AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cal_req |=> !cal_req);                                // R8
    AST_WAKE_SHIP: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(ship_mode));                       // R9
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> !stretch_over);                        // R7
endmodule

bind smb_line_watchdog smb_line_watchdog_chk u_chk (
    .clk(clk), .rst(rst), .abort_pulse(abort_pulse), .stretch_over(stretch_over),
    .cal_req(cal_req), .wake_req(wake_req), .ship_mode(ship_mode),
    .busy_q(busy_q), .start_seen(start_seen)
);

// File: tb/smb_line_watchdog_bench.sv
module smb_line_watchdog_bench;
    localparam int TL = 300, TH = 40, TN = 10, TS = 60, TM = 40, TC = 500;

    logic clk = 1'b0, rst = 1'b1;
    logic scl_in = 1'b1, sda_in = 1'b1, slv_hold_scl = 1'b0, ship_mode = 1'b0;
    logic abort_pulse, stretch_over, cal_req, wake_req;

    int total = 0, bad = 0, cycles = 0;
    int n_abort = 0, n_cal = 0, n_wake = 0;

    always #5 clk = ~clk;

    smb_line_watchdog #(
        .T_LOW_ABORT(TL), .T_HIGH_ABORT(TH), .T_LOW_NOMINAL(TN),
        .T_SLV_EXT(TS), .T_MST_EXT(TM), .T_CAL(TC)
    ) u_smb_line_watchdog (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .slv_hold_scl(slv_hold_scl), .ship_mode(ship_mode),
        .abort_pulse(abort_pulse), .stretch_over(stretch_over),
        .cal_req(cal_req), .wake_req(wake_req)
    );

    // behavioural reference
    bit f1c, f1d, sc, sd, pc, pd, busy;
    bit m_abort, m_flag, m_cal, m_wake;
    int lowc, highc, slvc, mstc, bothc;

    always @(posedge clk) begin
        bit st, sp, low_hit, high_hit, slv_en, mst_en, slv_hit, mst_hit, both_hit, ab;
        if (rst) begin
            f1c = 1; f1d = 1; sc = 1; sd = 1; pc = 1; pd = 1; busy = 0;
            lowc = 0; highc = 0; slvc = 0; mstc = 0; bothc = 0;
            m_abort = 0; m_flag = 0; m_cal = 0; m_wake = 0;
        end else begin
            st = pc && sc && pd && !sd;
            sp = pc && sc && !pd && sd;
            low_hit  = !sc && lowc == TL - 1;
            high_hit = sc && !st && highc == TH - 1;
            slv_en   = busy && !sc && slv_hold_scl;
            mst_en   = busy && !sc && !slv_hold_scl && lowc >= TN;
            slv_hit  = !st && slv_en && slvc == TS - 1;
            mst_hit  = !st && mst_en && mstc == TM - 1;
            both_hit = !sc && !sd && bothc == TC - 1;
            ab       = busy && (low_hit || high_hit);
            m_abort  = ab;
            m_cal    = both_hit;
            m_wake   = ship_mode && (sc != pc || sd != pd);
            m_flag   = st ? 0 : (m_flag || slv_hit || mst_hit);
            busy     = st ? 1 : ((sp || ab) ? 0 : busy);
            lowc  = sc ? 0 : (lowc < TL ? lowc + 1 : lowc);
            highc = (!sc || st) ? 0 : (highc < TH ? highc + 1 : highc);
            slvc  = st ? 0 : ((slv_en && slvc < TS) ? slvc + 1 : slvc);
            mstc  = st ? 0 : ((mst_en && mstc < TM) ? mstc + 1 : mstc);
            bothc = (sc || sd) ? 0 : (bothc < TC ? bothc + 1 : bothc);
            pc = sc; pd = sd; sc = f1c; sd = f1d; f1c = scl_in; f1d = sda_in;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk(abort_pulse,  m_abort, "R3/R4 abort vs model");
            chk(stretch_over, m_flag,  "R5/R6 flag vs model");
            chk(cal_req,      m_cal,   "R8 cal vs model");
            chk(wake_req,     m_wake,  "R9 wake vs model");
            n_abort += abort_pulse;
            n_cal   += cal_req;
            n_wake  += wake_req;
        end
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic drive(input bit c, input bit d, input bit h, input int n);
        @(negedge clk);
        scl_in = c; sda_in = d; slv_hold_scl = h;
        repeat (n) @(posedge clk);
    endtask

    task automatic do_start();
        drive(1, 1, 0, 4);
        drive(1, 0, 0, 4);
    endtask

    task automatic do_stop();
        drive(0, 0, 0, 4);
        drive(1, 0, 0, 4);
        drive(1, 1, 0, 10);
    endtask

    initial begin
        int base;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(abort_pulse | stretch_over | cal_req | wake_req, 0, "R1 outputs in reset");
        rst = 1'b0;
        drive(1, 1, 0, 6);
        chk(abort_pulse | stretch_over | cal_req | wake_req, 0, "R1 outputs after reset");

        // R2 clean message
        base = n_abort;
        do_start();
        for (int i = 0; i < 9; i++) begin
            drive(0, i[0], 0, 6);
            drive(1, i[0], 0, 6);
        end
        do_stop();
        chk(n_abort - base, 0, "R2 clean message no abort");
        chk(stretch_over, 0, "R2 clean message no flag");

        // R3 idle long low clock: no abort
        base = n_abort;
        drive(0, 1, 0, 400);
        drive(1, 1, 0, 10);
        chk(n_abort - base, 0, "R3 idle low no abort");

        // R3/R10 low clock inside message
        base = n_abort;
        do_start();
        drive(0, 0, 0, 450);
        drive(1, 0, 0, 4);
        drive(1, 1, 0, 10);
        chk(n_abort - base, 1, "R3 R10 single abort on low clock");

        // R4 high clock after START
        base = n_abort;
        do_start();
        drive(1, 0, 0, 100);
        do_stop();
        chk(n_abort - base, 1, "R4 abort on clock high");

        // R5 slave stretch
        do_start();
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 1, 25);
            drive(1, 0, 0, 6);
        end
        chk(stretch_over, 1, "R5 slave stretch flag");
        do_stop();
        chk(stretch_over, 1, "R7 flag held after stop");
        do_start();
        drive(1, 0, 0, 4);
        chk(stretch_over, 0, "R7 flag cleared by start");

        // R6 master extension
        drive(0, 0, 0, 30);
        drive(1, 0, 0, 6);
        chk(stretch_over, 0, "R6 below master budget");
        for (int i = 0; i < 2; i++) begin
            drive(0, 0, 0, 30);
            drive(1, 0, 0, 6);
        end
        chk(stretch_over, 1, "R6 master budget reached");
        do_stop();

        // R8 calibration
        base = n_cal;
        drive(0, 1, 0, 5);
        drive(0, 0, 0, 600);
        drive(0, 1, 0, 5);
        drive(0, 0, 0, 600);
        drive(0, 1, 0, 5);
        drive(0, 0, 0, 400);
        drive(0, 1, 0, 5);
        drive(1, 1, 0, 10);
        chk(n_cal - base, 2, "R8 one request per long episode");

        // R9 wake
        base = n_wake;
        drive(0, 1, 0, 5);
        drive(0, 0, 0, 5);
        drive(0, 1, 0, 5);
        chk(n_wake - base, 0, "R9 no wake outside ship state");
        ship_mode = 1'b1;
        drive(0, 1, 0, 8);
        chk(n_wake - base, 0, "R9 no wake on quiet bus");
        drive(0, 0, 0, 5);
        drive(0, 1, 0, 5);
        drive(0, 0, 0, 5);
        drive(0, 0, 0, 5);
        chk(n_wake - base, 3, "R9 wake per line change");
        ship_mode = 1'b0;
        drive(0, 1, 0, 5);
        drive(1, 1, 0, 10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule